// File: doc/BRIEF.md
# Dual-Rail Completion Detection Stage

This block is a clock-driven, synthesizable model of one stage in a two-phase, dual-rail self-timed channel. Each logical bit arrives on a pair of wires. One wire of the pair signals a 1 and the other signals a 0. Words alternate between a data set, in which every pair carries exactly one active rail, and a spacer set, in which no rail of any pair is active. The stage decodes every pair and reports when the whole bus holds data and when it has fully returned to spacer. It drives a single acknowledge output with hysteresis from a pyramid of Muller C-elements, captures the decoded word when a data phase completes, and flags protocol violations.

The tree fan-in `ARITY` may be set from 2 to 4. Every tree node rises only when all of its children are 1, falls only when all of them are 0, and otherwise holds its value. A parameter chooses the rail convention. In the normal convention the spacer is both rails low. In the complementary convention the spacer is both rails high, and a rail is active when it is low.

A two-state phase tracker runs alongside the tree. It starts in PH_DATA, where the stage is waiting for a data word to complete. When the acknowledge output is high, it moves to PH_SPACER. When the acknowledge output is low again, it returns to PH_DATA. The error checks and the word capture depend on the current phase.

Top module: `dr_completion_stage`

## Requirements
- R1: The pair (rail_one, rail_zero) is read as follows in the normal convention (SPACER_HIGH=0): (1,0) is data 1, (0,1) is data 0, (0,0) is spacer and (1,1) is illegal. With SPACER_HIGH=1, every rail level is inverted before this reading.
- R2: `data_done` is 1 in exactly those cycles in which every pair holds a legal data code. `null_done` is 1 in exactly those cycles in which every pair is spacer. Both flags follow the inputs in the same cycle.
- R3: `ack` rises in the same cycle that the last pair becomes valid data, and never earlier in the data phase.
- R4: `ack` falls in the same cycle that the last pair returns to spacer, and never earlier. In a mixed state (`data_done` and `null_done` both 0), `ack` keeps its previous value.
- R5: `word_q` shows the decoded word from the cycle after `ack` rises. It holds that value through the spacer phase and the next data phase, until the next data phase completes.
- R6: A pair in the illegal code never counts as valid data. It sets `err_code`, which stays set until reset.
- R7: `err_order` is set, and stays set until reset, in any of these cases:
  - in PH_DATA, a pair leaves a data code;
  - in PH_SPACER, a spacer pair takes a data code;
  - in either phase, a pair flips directly between data 0 and data 1.
  
  A data word that follows another data word with no spacer in between is therefore flagged.
- R8: While `rst` is high at a clock edge, every tree node is cleared, the tracker returns to PH_DATA, and `word_q`, `err_code` and `err_order` are cleared. `ack` is 0 after reset while the bus is spacer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rail_one | input | WIDTH | Rail of each pair that signals a 1 |
| rail_zero | input | WIDTH | Rail of each pair that signals a 0 |
| ack | output | WIDTH>0 ? 1 : 1 | Completion acknowledge from the C-element tree |
| data_done | output | 1 | Every pair holds legal data |
| null_done | output | 1 | Every pair is spacer |
| word_q | output | WIDTH | Word captured when a data phase completes |
| err_code | output | 1 | Sticky flag: illegal pair code seen |
| err_order | output | 1 | Sticky flag: ordering violation seen |

## Verification
The completion assertions assume an environment that obeys the protocol: pairs change only monotonically within a phase, and no illegal code appears. The tree's hysteresis matches the all-valid and all-spacer conditions only under that assumption, so those properties are gated off once an illegal code or an ordering violation has been seen. The random stimulus changes one pair per cycle in a random order, and it always inserts a full spacer word between data words. Separate directed sequences inject an illegal code, a back-to-back data word and an early withdrawal of a data bit; they check only the error flags and the outputs that remain well defined after such a violation.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic {
        PH_DATA   = 1'b0,
        PH_SPACER = 1'b1
    } phase_e;

    // number of nodes present at a tree level (level 0 = leaves)
    function automatic int nodes_at(input int w, input int a, input int lvl);
        int n;
        n = w;
        for (int i = 0; i < lvl; i++) n = (n + a - 1) / a;
        return n;
    endfunction

    // number of C-element levels above the leaves (at least one)
    function automatic int tree_levels(input int w, input int a);
        int n;
        int l;
        n = w;
        l = 0;
        while (n > 1) begin
            n = (n + a - 1) / a;
            l++;
        end
        if (l == 0) l = 1;
        return l;
    endfunction

    // bit offset of a level inside the flattened node vector
    function automatic int level_offset(input int w, input int a, input int lvl);
        int s;
        s = 0;
        for (int k = 0; k < lvl; k++) s += nodes_at(w, a, k);
        return s;
    endfunction

endpackage

// File: rtl/dr_celem.sv
module dr_celem #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] a,
    output logic         y
);
    logic held_q;

    // rise when all children high, fall when all low, otherwise hold
    assign y = (&a) | ((|a) & held_q);

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= y;
    end

endmodule

// File: rtl/dr_rail_decode.sv
module dr_rail_decode #(
    parameter int WIDTH       = 8,
    parameter bit SPACER_HIGH = 1'b0
) (
    input  logic [WIDTH-1:0] rail_one,
    input  logic [WIDTH-1:0] rail_zero,
    output logic [WIDTH-1:0] valid,
    output logic [WIDTH-1:0] spacer,
    output logic [WIDTH-1:0] illegal,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] IDLE = {WIDTH{SPACER_HIGH}};

    logic [WIDTH-1:0] one_act;
    logic [WIDTH-1:0] zero_act;

    assign one_act  = rail_one  ^ IDLE;
    assign zero_act = rail_zero ^ IDLE;

    assign valid   = one_act ^ zero_act;
    assign spacer  = ~(one_act | zero_act);
    assign illegal = one_act & zero_act;
    assign value   = one_act;

endmodule

// File: rtl/dr_completion_tree.sv
module dr_completion_tree #(
    parameter int WIDTH = 8,
    parameter int ARITY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] leaf,
    output logic             done
);
    localparam int LEVELS = dr_pkg::tree_levels(WIDTH, ARITY);
    localparam int TOTAL  = dr_pkg::level_offset(WIDTH, ARITY, LEVELS + 1);

    // leaves first, then each level of nodes, root last
    logic [TOTAL-1:0] net;

    assign net[WIDTH-1:0] = leaf;

    for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
        localparam int NPREV = dr_pkg::nodes_at(WIDTH, ARITY, l - 1);
        localparam int NCUR  = dr_pkg::nodes_at(WIDTH, ARITY, l);
        localparam int OPREV = dr_pkg::level_offset(WIDTH, ARITY, l - 1);
        localparam int OCUR  = dr_pkg::level_offset(WIDTH, ARITY, l);
        for (genvar j = 0; j < NCUR; j++) begin : g_node
            localparam int BASE = j * ARITY;
            localparam int NCH  = (NPREV - BASE < ARITY) ? (NPREV - BASE) : ARITY;
            dr_celem #(.N(NCH)) u_node (
                .clk (clk),
                .rst (rst),
                .a   (net[OPREV + BASE +: NCH]),
                .y   (net[OCUR + j])
            );
        end
    end

    assign done = net[TOTAL-1];

endmodule

// File: rtl/dr_completion_stage.sv
module dr_completion_stage #(
    parameter int WIDTH       = 8,
    parameter int ARITY       = 2,
    parameter bit SPACER_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rail_one,
    input  logic [WIDTH-1:0] rail_zero,
    output logic             ack,
    output logic             data_done,
    output logic             null_done,
    output logic [WIDTH-1:0] word_q,
    output logic             err_code,
    output logic             err_order
);
    import dr_pkg::*;

    logic [WIDTH-1:0] valid_v, spacer_v, illegal_v, value_v;
    logic [WIDTH-1:0] prev_valid_q, prev_spacer_q, prev_value_q;
    logic [WIDTH-1:0] flip_v, bad_v;
    phase_e           phase_q, phase_d;

    dr_rail_decode #(.WIDTH(WIDTH), .SPACER_HIGH(SPACER_HIGH)) u_decode (
        .rail_one  (rail_one),
        .rail_zero (rail_zero),
        .valid     (valid_v),
        .spacer    (spacer_v),
        .illegal   (illegal_v),
        .value     (value_v)
    );

    dr_completion_tree #(.WIDTH(WIDTH), .ARITY(ARITY)) u_tree (
        .clk  (clk),
        .rst  (rst),
        .leaf (valid_v),
        .done (ack)
    );

    assign data_done = &valid_v;
    assign null_done = &spacer_v;

    // phase transitions
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_DATA:   if (ack)  phase_d = PH_SPACER;
            PH_SPACER: if (!ack) phase_d = PH_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_DATA;
        else     phase_q <= phase_d;
    end

    // per-pair ordering rules
    assign flip_v = prev_valid_q & valid_v & (prev_value_q ^ value_v);

    always_comb begin
        bad_v = '0;
        unique case (phase_q)
            PH_DATA:   bad_v = (prev_valid_q & ~valid_v) | flip_v;
            PH_SPACER: bad_v = (prev_spacer_q & valid_v) | flip_v;
        endcase
    end

    // registered outputs and history
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q        <= '0;
            err_code      <= 1'b0;
            err_order     <= 1'b0;
            prev_valid_q  <= '0;
            prev_spacer_q <= '1;
            prev_value_q  <= '0;
        end else begin
            if (phase_q == PH_DATA && ack) word_q <= value_v;
            if (|illegal_v) err_code  <= 1'b1;
            if (|bad_v)     err_order <= 1'b1;
            prev_valid_q  <= valid_v;
            prev_spacer_q <= spacer_v;
            prev_value_q  <= value_v;
        end
    end

    // ---------------- assertions ----------------
    logic proto_ok;
    assign proto_ok = !err_code && !err_order && !(|bad_v) && !(|illegal_v);

    p_rise_needs_data_r3: assert property (@(posedge clk) disable iff (rst)
        (proto_ok && phase_q == PH_DATA && ack) |-> data_done);

    p_fall_needs_null_r4: assert property (@(posedge clk) disable iff (rst)
        (proto_ok && phase_q == PH_SPACER && !ack) |-> null_done);

    p_hold_mixed_r4: assert property (@(posedge clk) disable iff (rst)
        (proto_ok && !data_done && !null_done) |-> (ack == (phase_q == PH_SPACER)));

    p_word_held_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SPACER) |=> $stable(word_q));

    p_code_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err_code |=> err_code);

    p_order_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_order |=> err_order);

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!err_code && !err_order && word_q == '0));

endmodule

// File: tb/dr_completion_stage_tb.sv
module dr_completion_stage_tb;
    localparam int WIDTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [WIDTH-1:0] r1, r0, r1_inv, r0_inv;
    logic ack_a, dd_a, nd_a, ec_a, eo_a;
    logic ack_b, dd_b, nd_b, ec_b, eo_b;
    logic [WIDTH-1:0] w_a, w_b;

    always #4 clk = ~clk;

    dr_completion_stage #(.WIDTH(WIDTH), .ARITY(2), .SPACER_HIGH(1'b0)) u_dut (
        .clk(clk), .rst(rst), .rail_one(r1), .rail_zero(r0),
        .ack(ack_a), .data_done(dd_a), .null_done(nd_a), .word_q(w_a),
        .err_code(ec_a), .err_order(eo_a));

    // complementary convention (R1), driven with inverted rails
    dr_completion_stage #(.WIDTH(WIDTH), .ARITY(4), .SPACER_HIGH(1'b1)) u_dut_inv (
        .clk(clk), .rst(rst), .rail_one(r1_inv), .rail_zero(r0_inv),
        .ack(ack_b), .data_done(dd_b), .null_done(nd_b), .word_q(w_b),
        .err_code(ec_b), .err_order(eo_b));

    // bit codes: 0 spacer, 1 data0, 2 data1, 3 illegal
    int cur [WIDTH];
    int m_prev [WIDTH];
    int m_phase;            // 0 data, 1 spacer
    bit m_ack, m_errc, m_erro;
    logic [WIDTH-1:0] m_word;
    bit chk_ack;
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic check(input string req, input string what, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic apply();
        for (int b = 0; b < WIDTH; b++) begin
            r1[b] = (cur[b] == 2 || cur[b] == 3);
            r0[b] = (cur[b] == 1 || cur[b] == 3);
        end
        r1_inv = ~r1;
        r0_inv = ~r0;
    endtask

    task automatic model_reset();
        m_phase = 0; m_ack = 0; m_errc = 0; m_erro = 0; m_word = '0;
        for (int b = 0; b < WIDTH; b++) m_prev[b] = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int b = 0; b < WIDTH; b++) cur[b] = 0;
        apply();
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        model_reset();
        chk_ack = 1;
    endtask

    // apply current codes, compare at negedge, advance model
    task automatic step();
        bit allv, alls, any_ill, any_bad, nack;
        bit pv, cv, ps, flip;
        logic [WIDTH-1:0] dec;
        apply();
        @(negedge clk);
        allv = 1; alls = 1; any_ill = 0; any_bad = 0;
        for (int b = 0; b < WIDTH; b++) begin
            cv = (cur[b] == 1 || cur[b] == 2);
            pv = (m_prev[b] == 1 || m_prev[b] == 2);
            ps = (m_prev[b] == 0);
            flip = pv && cv && (m_prev[b] != cur[b]);
            if (!cv) allv = 0;
            if (cur[b] != 0) alls = 0;
            if (cur[b] == 3) any_ill = 1;
            if (m_phase == 0 && pv && (!cv || flip)) any_bad = 1;
            if (m_phase == 1 && ((ps && cv) || flip)) any_bad = 1;
            dec[b] = (cur[b] == 2);
        end
        nack = allv ? 1'b1 : (alls ? 1'b0 : m_ack);
        check("R2", "data_done", {{(WIDTH-1){1'b0}}, dd_a}, {{(WIDTH-1){1'b0}}, allv});
        check("R2", "null_done", {{(WIDTH-1){1'b0}}, nd_a}, {{(WIDTH-1){1'b0}}, alls});
        check("R1 R2", "inv data_done", {{(WIDTH-1){1'b0}}, dd_b}, {{(WIDTH-1){1'b0}}, allv});
        check("R1 R2", "inv null_done", {{(WIDTH-1){1'b0}}, nd_b}, {{(WIDTH-1){1'b0}}, alls});
        if (chk_ack) begin
            if (m_ack == 0) begin
                check("R3", "ack", {{(WIDTH-1){1'b0}}, ack_a}, {{(WIDTH-1){1'b0}}, nack});
                check("R3", "inv ack", {{(WIDTH-1){1'b0}}, ack_b}, {{(WIDTH-1){1'b0}}, nack});
            end else begin
                check("R4", "ack", {{(WIDTH-1){1'b0}}, ack_a}, {{(WIDTH-1){1'b0}}, nack});
                check("R4", "inv ack", {{(WIDTH-1){1'b0}}, ack_b}, {{(WIDTH-1){1'b0}}, nack});
            end
            check("R1 R5", "word_q", w_a, m_word);
            check("R1 R5", "inv word_q", w_b, m_word);
        end
        check("R6", "err_code", {{(WIDTH-1){1'b0}}, ec_a}, {{(WIDTH-1){1'b0}}, m_errc});
        check("R6", "inv err_code", {{(WIDTH-1){1'b0}}, ec_b}, {{(WIDTH-1){1'b0}}, m_errc});
        check("R7", "err_order", {{(WIDTH-1){1'b0}}, eo_a}, {{(WIDTH-1){1'b0}}, m_erro});
        check("R7", "inv err_order", {{(WIDTH-1){1'b0}}, eo_b}, {{(WIDTH-1){1'b0}}, m_erro});
        if (m_phase == 0 && nack) m_word = dec;
        if (m_phase == 0 && nack) m_phase = 1;
        else if (m_phase == 1 && !nack) m_phase = 0;
        m_ack = nack;
        if (any_ill) m_errc = 1;
        if (any_bad) m_erro = 1;
        for (int b = 0; b < WIDTH; b++) m_prev[b] = cur[b];
        @(posedge clk);
        #1;
    endtask

    task automatic send_word(input logic [WIDTH-1:0] w);
        int perm [WIDTH];
        int j, t;
        for (int i = 0; i < WIDTH; i++) perm[i] = i;
        for (int i = WIDTH - 1; i > 0; i--) begin
            j = $urandom_range(i, 0);
            t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        for (int i = 0; i < WIDTH; i++) begin
            cur[perm[i]] = w[perm[i]] ? 2 : 1;
            step();   // R3: ack must stay low until the last pair lands
        end
        step();
        for (int i = WIDTH - 1; i > 0; i--) begin
            j = $urandom_range(i, 0);
            t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        for (int i = 0; i < WIDTH; i++) begin
            cur[perm[i]] = 0;
            step();   // R4: ack must hold until the last pair is spacer
        end
        step();
    endtask

    initial begin
        r1 = '0; r0 = '0; r1_inv = '1; r0_inv = '1;
        chk_ack = 1;
        for (int b = 0; b < WIDTH; b++) cur[b] = 0;
        do_reset();
        // R8: reset state
        @(negedge clk);
        check("R8", "ack after reset", {{(WIDTH-1){1'b0}}, ack_a}, '0);
        check("R8", "word after reset", w_a, '0);
        check("R8", "errors after reset", {{(WIDTH-2){1'b0}}, ec_a, eo_a}, '0);
        @(posedge clk); #1;

        send_word('0);
        send_word('1);
        send_word(8'hA5);
        for (int k = 0; k < 30; k++) send_word($urandom_range(255, 0));

        // R6: illegal code blocks completion and sets sticky flag
        for (int b = 0; b < WIDTH - 1; b++) begin cur[b] = 2; step(); end
        cur[WIDTH-1] = 3; step();
        step();
        check("R6", "ack low with illegal pair", {{(WIDTH-1){1'b0}}, ack_a}, '0);
        do_reset();
        step();
        check("R8", "err_code cleared", {{(WIDTH-1){1'b0}}, ec_a}, '0);

        // R7: back-to-back data word (flip without spacer)
        for (int b = 0; b < WIDTH; b++) begin cur[b] = 1; step(); end
        step();
        chk_ack = 0;
        cur[0] = 2; step();
        step();
        check("R7", "back-to-back flagged", {{(WIDTH-1){1'b0}}, eo_a}, 1);
        do_reset();
        step();

        // R7: data bit withdrawn before completion
        cur[2] = 2; step();
        cur[5] = 1; step();
        chk_ack = 0;
        cur[2] = 0; step();
        step();
        check("R7", "early withdrawal flagged", {{(WIDTH-1){1'b0}}, eo_a}, 1);
        do_reset();
        step();

        // R7: spacer pair re-entering data in spacer phase
        for (int b = 0; b < WIDTH; b++) begin cur[b] = 2; step(); end
        cur[3] = 0; step();
        chk_ack = 0;
        cur[3] = 1; step();
        step();
        check("R7", "re-entry flagged", {{(WIDTH-1){1'b0}}, eo_a}, 1);
        do_reset();
        send_word(8'h3C);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule